// File: doc/BRIEF.md
# CPU Presence Bitmap with Hotplug Event Flag

This block keeps one presence bit per CPU identifier and shows the whole map to
software as a small read-only byte window. Each byte of the window carries eight
consecutive identifiers: identifier `n` lives in byte `n/8` at bit `n mod 8`, so
software walks the window one byte at a time in little-endian order. With the
default parameters the map covers identifiers 0 to 255 in a 32-byte window.

Hardware reports CPU arrivals and departures as single-cycle events tagged with
an identifier. An arrival sets the matching bit and a departure clears it. Every
accepted event, whatever it changes, pulses the hotplug bit (bit 2) of a
general-purpose-event set vector, and the event aggregator next to this block ORs
that pulse into its status register so it can re-evaluate its interrupt.
During reset the map is loaded from a start-up presence vector with no
event pulse. An identifier beyond the map is dropped and latches an error flag.

Top module: `cpuhp_bitmap`

## Requirements
- R1: While `rst_n` is low (sampled at the clock edge) the map is loaded from `init_map`, and `rd_data`, `gpe_sts_set` and `id_err` are all zero; no event pulse comes from the reset load.
- R2: A byte read (access enabled, write low, size code 0) at offset `k` below the window length returns, one clock later on `rd_data`, the map byte holding identifiers `8k` to `8k+7`, identifier `8k+j` on bit `j`.
- R3: An accepted arrival event (`evt_valid` high, `evt_plug` high, identifier in range) sets the identifier's bit from the next clock on and leaves every other bit unchanged.
- R4: An accepted departure event (`evt_valid` high, `evt_plug` low, identifier in range) clears the identifier's bit from the next clock on and leaves every other bit unchanged.
- R5: Each accepted event, including one that does not change its bit, makes `gpe_sts_set` equal to a vector with only bit `HP_BIT` (default 2) set for exactly one clock, the clock after the event; otherwise `gpe_sts_set` is zero.
- R6: A read with size code 1 (two bytes) or 2 (four bytes) or 3 is not a valid access: `rd_data` is zero the clock after.
- R7: A write access (access enabled, write high) leaves the map unchanged and gives zero on `rd_data` the clock after.
- R8: An event whose identifier is `NUM_IDS` or more changes no bit, gives no pulse on `gpe_sts_set`, and sets `id_err` from the next clock on; `id_err` then stays high until reset.
- R9: A byte read at an offset equal to or beyond the window length (`NUM_IDS/8`) returns zero.
- R10: A read issued in the same clock as an event returns the map as it was before that event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the start-up map |
| init_map | input | NUM_IDS | Start-up presence vector, bit `n` for identifier `n` |
| evt_valid | input | 1 | Hotplug event strobe, one event per clock |
| evt_plug | input | 1 | 1 for arrival, 0 for departure |
| evt_id | input | EVT_W | Identifier tagged on the event |
| acc_en | input | 1 | Register-window access strobe |
| acc_we | input | 1 | 1 for write access (ignored), 0 for read |
| acc_size | input | 2 | Access size code: 0 byte, 1 two bytes, 2 four bytes, 3 reserved |
| acc_addr | input | ADDR_W | Byte offset inside the window |
| rd_data | output | 8 | Registered read data |
| gpe_sts_set | output | GPE_W | One-clock set pulse toward the event status register |
| id_err | output | 1 | Sticky flag for a dropped out-of-range event |

## Verification
The bench builds the block with `NUM_IDS=40`, `EVT_W=8` and `ADDR_W=4`, so the window is five bytes long. That leaves identifiers 40 to 255 encodable on the event port, which puts the dropped-event path and the sticky error flag within reach, and offsets 5 to 15 addressable, which exercises the zero return beyond the window. The small map also lets a short vector table touch every byte, including the last, partly-populated-by-reset one.

// File: rtl/cpuhp_pkg.sv
package cpuhp_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_QUAD  = 2'd2,
        SZ_RSVD  = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic hp_pulse;
        logic err;
    } ctl_state_t;

endpackage

// File: rtl/cpuhp_evt_dec.sv
module cpuhp_evt_dec #(
    parameter int NUM_IDS = 256,
    parameter int EVT_W   = 9
) (
    input  logic               evt_valid,
    input  logic               evt_plug,
    input  logic [EVT_W-1:0]   evt_id,
    output logic [NUM_IDS-1:0] set_mask,
    output logic [NUM_IDS-1:0] clr_mask,
    output logic               accept,
    output logic               reject
);

    logic in_range;

    always_comb begin
        in_range = (int'(evt_id) < NUM_IDS);
        accept   = evt_valid && in_range;
        reject   = evt_valid && !in_range;
    end

    // One-hot decode of the identifier, qualified by direction.
    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        for (int i = 0; i < NUM_IDS; i++) begin
            if (accept && (evt_id == EVT_W'(i))) begin
                set_mask[i] = evt_plug;
                clr_mask[i] = !evt_plug;
            end
        end
    end

endmodule

// File: rtl/cpuhp_map.sv
module cpuhp_map #(
    parameter int NUM_IDS = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IDS-1:0] init_map,
    input  logic [NUM_IDS-1:0] set_mask,
    input  logic [NUM_IDS-1:0] clr_mask,
    output logic [NUM_IDS-1:0] map_q
);

    localparam int NBYTES = NUM_IDS / cpuhp_pkg::BYTE_W;

    logic [NUM_IDS-1:0] map_d;

    // Each byte lane is updated on its own; a lane with no hit holds.
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        localparam int LO = b * cpuhp_pkg::BYTE_W;
        always_comb begin
            map_d[LO +: cpuhp_pkg::BYTE_W] =
                (map_q[LO +: cpuhp_pkg::BYTE_W] & ~clr_mask[LO +: cpuhp_pkg::BYTE_W])
                | set_mask[LO +: cpuhp_pkg::BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= init_map;
        end else begin
            map_q <= map_d;
        end
    end

endmodule

// File: rtl/cpuhp_rd.sv
module cpuhp_rd #(
    parameter int NUM_IDS = 256,
    parameter int ADDR_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IDS-1:0] map_q,
    input  logic               acc_en,
    input  logic               acc_we,
    input  logic [1:0]         acc_size,
    input  logic [ADDR_W-1:0]  acc_addr,
    output logic [7:0]         rd_data
);

    import cpuhp_pkg::*;

    localparam int NBYTES = NUM_IDS / BYTE_W;

    logic [7:0] rd_d;
    logic [7:0] rd_q;
    logic       rd_ok;
    logic [7:0] lane_sel;

    always_comb begin
        rd_ok = acc_en && !acc_we && (acc_size_e'(acc_size) == SZ_BYTE);
        lane_sel = '0;
        for (int b = 0; b < NBYTES; b++) begin
            if (acc_addr == ADDR_W'(b)) begin
                lane_sel = map_q[b*BYTE_W +: BYTE_W];
            end
        end
        rd_d = rd_ok ? lane_sel : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/cpuhp_bitmap.sv
module cpuhp_bitmap #(
    parameter int NUM_IDS = 256,
    parameter int EVT_W   = 9,
    parameter int ADDR_W  = 6,
    parameter int GPE_W   = 8,
    parameter int HP_BIT  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IDS-1:0] init_map,
    input  logic               evt_valid,
    input  logic               evt_plug,
    input  logic [EVT_W-1:0]   evt_id,
    input  logic               acc_en,
    input  logic               acc_we,
    input  logic [1:0]         acc_size,
    input  logic [ADDR_W-1:0]  acc_addr,
    output logic [7:0]         rd_data,
    output logic [GPE_W-1:0]   gpe_sts_set,
    output logic               id_err
);

    import cpuhp_pkg::*;

    logic [NUM_IDS-1:0] set_mask;
    logic [NUM_IDS-1:0] clr_mask;
    logic [NUM_IDS-1:0] map_q;
    logic               accept;
    logic               reject;
    ctl_state_t         ctl_d;
    ctl_state_t         ctl_q;

    cpuhp_evt_dec #(
        .NUM_IDS (NUM_IDS),
        .EVT_W   (EVT_W)
    ) u_dec (
        .evt_valid (evt_valid),
        .evt_plug  (evt_plug),
        .evt_id    (evt_id),
        .set_mask  (set_mask),
        .clr_mask  (clr_mask),
        .accept    (accept),
        .reject    (reject)
    );

    cpuhp_map #(
        .NUM_IDS (NUM_IDS)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_map (init_map),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .map_q    (map_q)
    );

    cpuhp_rd #(
        .NUM_IDS (NUM_IDS),
        .ADDR_W  (ADDR_W)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .map_q    (map_q),
        .acc_en   (acc_en),
        .acc_we   (acc_we),
        .acc_size (acc_size),
        .acc_addr (acc_addr),
        .rd_data  (rd_data)
    );

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.hp_pulse = accept;
        ctl_d.err      = ctl_q.err | reject;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar g = 0; g < GPE_W; g++) begin : g_gpe
        if (g == HP_BIT) begin : g_hp
            assign gpe_sts_set[g] = ctl_q.hp_pulse;
        end else begin : g_zero
            assign gpe_sts_set[g] = 1'b0;
        end
    end

    assign id_err = ctl_q.err;

endmodule

// File: rtl/cpuhp_bitmap_chk.sv
module cpuhp_bitmap_chk #(
    parameter int NUM_IDS = 256,
    parameter int EVT_W   = 9,
    parameter int ADDR_W  = 6,
    parameter int GPE_W   = 8,
    parameter int HP_BIT  = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               evt_valid,
    input logic               evt_plug,
    input logic [EVT_W-1:0]   evt_id,
    input logic               acc_en,
    input logic               acc_we,
    input logic [1:0]         acc_size,
    input logic [ADDR_W-1:0]  acc_addr,
    input logic [7:0]         rd_data,
    input logic [GPE_W-1:0]   gpe_sts_set,
    input logic               id_err,
    input logic [NUM_IDS-1:0] map_q
);

    localparam int IDX_W = $clog2(NUM_IDS);

    logic [IDX_W-1:0] id_q;
    logic             ok_evt;
    logic             bad_evt;

    always_comb begin
        ok_evt  = evt_valid && (int'(evt_id) < NUM_IDS);
        bad_evt = evt_valid && !(int'(evt_id) < NUM_IDS);
    end

    always_ff @(posedge clk) begin
        id_q <= evt_id[IDX_W-1:0];
    end

    a_r3_plug_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ok_evt && evt_plug |=> map_q[id_q]);

    a_r4_unplug_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ok_evt && !evt_plug |=> !map_q[id_q]);

    a_r5_pulse_follows_event: assert property (@(posedge clk) disable iff (!rst_n)
        ok_evt |=> gpe_sts_set[HP_BIT]);

    a_r5_single_source: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gpe_sts_set) <= 1);

    a_r6_wide_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && (acc_size != 2'd0) |=> (rd_data == 8'h00));

    a_r7_write_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && acc_we |=> (rd_data == 8'h00));

    a_r8_bad_id_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_evt |=> $stable(map_q));

    a_r8_bad_id_flags: assert property (@(posedge clk) disable iff (!rst_n)
        bad_evt |=> id_err && (gpe_sts_set == '0));

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        id_err |=> id_err);

    a_r9_offset_beyond: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && (int'(acc_addr) >= NUM_IDS / 8) |=> (rd_data == 8'h00));

endmodule

bind cpuhp_bitmap cpuhp_bitmap_chk #(
    .NUM_IDS (NUM_IDS),
    .EVT_W   (EVT_W),
    .ADDR_W  (ADDR_W),
    .GPE_W   (GPE_W),
    .HP_BIT  (HP_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_valid   (evt_valid),
    .evt_plug    (evt_plug),
    .evt_id      (evt_id),
    .acc_en      (acc_en),
    .acc_we      (acc_we),
    .acc_size    (acc_size),
    .acc_addr    (acc_addr),
    .rd_data     (rd_data),
    .gpe_sts_set (gpe_sts_set),
    .id_err      (id_err),
    .map_q       (map_q)
);

// File: tb/test_cpuhp_bitmap.sv
module test_cpuhp_bitmap;

    localparam int NUM_IDS = 40;
    localparam int EVT_W   = 8;
    localparam int ADDR_W  = 4;
    localparam int GPE_W   = 8;
    localparam int HP_BIT  = 2;
    localparam logic [GPE_W-1:0] HP_VEC = 8'h04;

    // Vector: kind[17:16] (0 arrival, 1 departure, 2 byte read), arg[15:8], expected[7:0]
    localparam int NVEC = 21;
    localparam logic [17:0] VEC [NVEC] = '{
        {2'd2, 8'd0,  8'h81},
        {2'd2, 8'd1,  8'h00},
        {2'd2, 8'd2,  8'h10},
        {2'd2, 8'd4,  8'h80},
        {2'd0, 8'd9,  8'h00},
        {2'd2, 8'd1,  8'h02},
        {2'd0, 8'd15, 8'h00},
        {2'd2, 8'd1,  8'h82},
        {2'd1, 8'd0,  8'h00},
        {2'd2, 8'd0,  8'h80},
        {2'd0, 8'd39, 8'h00},
        {2'd2, 8'd4,  8'h80},
        {2'd1, 8'd39, 8'h00},
        {2'd2, 8'd4,  8'h00},
        {2'd0, 8'd33, 8'h00},
        {2'd2, 8'd4,  8'h02},
        {2'd1, 8'd20, 8'h00},
        {2'd2, 8'd2,  8'h00},
        {2'd1, 8'd21, 8'h00},
        {2'd2, 8'd2,  8'h00},
        {2'd2, 8'd3,  8'h00}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_IDS-1:0] init_map = 40'h80_00_10_00_81;
    logic               evt_valid = 1'b0;
    logic               evt_plug = 1'b0;
    logic [EVT_W-1:0]   evt_id = '0;
    logic               acc_en = 1'b0;
    logic               acc_we = 1'b0;
    logic [1:0]         acc_size = 2'd0;
    logic [ADDR_W-1:0]  acc_addr = '0;
    logic [7:0]         rd_data;
    logic [GPE_W-1:0]   gpe_sts_set;
    logic               id_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cpuhp_bitmap #(
        .NUM_IDS (NUM_IDS),
        .EVT_W   (EVT_W),
        .ADDR_W  (ADDR_W),
        .GPE_W   (GPE_W),
        .HP_BIT  (HP_BIT)
    ) i_cpuhp_bitmap (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_map    (init_map),
        .evt_valid   (evt_valid),
        .evt_plug    (evt_plug),
        .evt_id      (evt_id),
        .acc_en      (acc_en),
        .acc_we      (acc_we),
        .acc_size    (acc_size),
        .acc_addr    (acc_addr),
        .rd_data     (rd_data),
        .gpe_sts_set (gpe_sts_set),
        .id_err      (id_err)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // Event driven for one clock; gpe pulse sampled on the next falling edge.
    task automatic send_evt(input logic plug, input int id, input logic [7:0] exp_gpe, input string req);
        @(negedge clk);
        evt_valid = 1'b1;
        evt_plug  = plug;
        evt_id    = EVT_W'(id);
        @(negedge clk);
        evt_valid = 1'b0;
        check(req, gpe_sts_set, exp_gpe);
    endtask

    task automatic access(input logic we, input logic [1:0] sz, input int addr,
                          input logic [7:0] exp, input string req);
        @(negedge clk);
        acc_en   = 1'b1;
        acc_we   = we;
        acc_size = sz;
        acc_addr = ADDR_W'(addr);
        @(negedge clk);
        acc_en = 1'b0;
        acc_we = 1'b0;
        check(req, rd_data, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 rd_data in reset", rd_data, 8'h00);
        check("R1 gpe in reset", gpe_sts_set, 8'h00);
        check("R1 id_err in reset", {7'd0, id_err}, 8'h00);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung expected finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        @(negedge clk);
        check("R1 no pulse after reset load", gpe_sts_set, 8'h00);

        // Table walk: R2 reads, R3 arrivals, R4 departures, R5 pulses.
        for (int v = 0; v < NVEC; v++) begin
            case (VEC[v][17:16])
                2'd0: send_evt(1'b1, int'(VEC[v][15:8]), HP_VEC, "R3 R5 arrival pulse");
                2'd1: send_evt(1'b0, int'(VEC[v][15:8]), HP_VEC, "R4 R5 departure pulse");
                default: access(1'b0, 2'd0, int'(VEC[v][15:8]), VEC[v][7:0], "R2 R3 R4 byte read");
            endcase
        end
        // Map now: b0=80 b1=82 b2=00 b3=00 b4=02
        @(negedge clk);
        check("R5 pulse lasts one clock", gpe_sts_set, 8'h00);

        access(1'b0, 2'd1, 1, 8'h00, "R6 two-byte read");
        access(1'b0, 2'd2, 1, 8'h00, "R6 four-byte read");
        access(1'b0, 2'd0, 1, 8'h82, "R6 byte read still valid");

        access(1'b1, 2'd0, 0, 8'h00, "R7 write returns zero");
        access(1'b0, 2'd0, 0, 8'h80, "R7 write left map unchanged");

        access(1'b0, 2'd0, 5, 8'h00, "R9 offset at window end");
        access(1'b0, 2'd0, 15, 8'h00, "R9 top offset");

        send_evt(1'b1, 40, 8'h00, "R8 out-of-range arrival no pulse");
        check("R8 error set", {7'd0, id_err}, 8'h01);
        send_evt(1'b0, 200, 8'h00, "R8 out-of-range departure no pulse");
        access(1'b0, 2'd0, 4, 8'h02, "R8 map byte 4 unchanged");
        access(1'b0, 2'd0, 0, 8'h80, "R8 map byte 0 unchanged");
        send_evt(1'b1, 1, HP_VEC, "R3 arrival after error");
        check("R8 error sticky", {7'd0, id_err}, 8'h01);
        access(1'b0, 2'd0, 0, 8'h82, "R3 id 1 set");

        // Read and event in the same clock.
        @(negedge clk);
        evt_valid = 1'b1; evt_plug = 1'b1; evt_id = EVT_W'(8);
        acc_en = 1'b1; acc_we = 1'b0; acc_size = 2'd0; acc_addr = ADDR_W'(1);
        @(negedge clk);
        evt_valid = 1'b0; acc_en = 1'b0;
        check("R10 read sees pre-event map", rd_data, 8'h82);
        access(1'b0, 2'd0, 1, 8'h83, "R10 event applied afterwards");

        do_reset();
        @(negedge clk);
        check("R1 error cleared by reset", {7'd0, id_err}, 8'h00);
        access(1'b0, 2'd0, 1, 8'h00, "R1 map reloaded byte 1");
        access(1'b0, 2'd0, 0, 8'h81, "R1 map reloaded byte 0");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule